// File: doc/BRIEF.md
# UART Interrupt Enable and Status Unit

This block collects thirteen single-cycle event pulses from a serial port (receive and transmit FIFO levels, line errors, timeouts, modem changes) and turns them into one interrupt line for the processor. Each event is caught in a sticky status bit. It stays set until software clears it by writing a one to that bit at the status offset.

Software controls which events may raise the interrupt through a mask. The mask has no plain write port. One offset sets mask bits where the written value has ones, a second offset clears mask bits where the written value has ones, and a third offset returns the current mask on a read. A zero bit written to either update offset leaves that mask bit alone. Several drivers can therefore change their own sources without a read-modify-write race.

The interrupt output is the OR of the status bits that are also masked in. It is registered, so it follows the status and mask registers one clock later.

Top module: `uart_irq_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, the mask, the status and `irqOut` are all zero.
- R2: A write at offset 0x08 sets every mask bit whose write-data bit is one. Mask bits whose write-data bit is zero keep their value.
- R3: A write at offset 0x0C clears every mask bit whose write-data bit is one. Mask bits whose write-data bit is zero keep their value.
- R4: A read at offset 0x10 returns the mask in bits 12..0 and zero in all higher bits. A write to 0x10 does not change the mask.
- R5: An event pulse on `srcEvt[n]` sets status bit n at the next clock edge. The bit then stays set, whatever its event input does, until software clears it. A read at offset 0x14 returns the status in bits 12..0 and zero above.
- R6: A write at offset 0x14 clears every status bit whose write-data bit is one. Status bits whose write-data bit is zero are unchanged.
- R7: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: `irqOut` equals the OR over all bits of (status AND mask), taken one clock earlier.
- R9: A read at 0x08, at 0x0C or at any unmapped offset returns zero. A write to an unmapped offset changes neither the mask nor the status.
- R10: Status and mask bit n belong to event input n, with this assignment: 0 receive level reached, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 receive overflow, 6 framing error, 7 parity error, 8 receive timeout, 9 modem status change, 10 transmit level reached, 11 transmit almost full, 12 transmit overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W (8) | Register byte offset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data for `busAddr`, combinational |
| srcEvt | input | NUM_SRC (13) | Event pulses, one per source |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The properties assume a synchronous bus: one address per cycle, `busWr` high for exactly one cycle per write, and `srcEvt` sampled on every edge. They also assume no event input is held as an unknown. The bench changes every input one time unit after a rising edge and samples at the falling edge, so each write and each event pulse is applied to exactly one edge. Events are raised only as whole-cycle pulses or deliberate multi-cycle levels. The corner cases are exercised directly: a clear and an event on the same bit, writes to the read-only mask offset, and writes to unmapped offsets.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned OFS_MASK_SET = 'h08;
  localparam int unsigned OFS_MASK_CLR = 'h0C;
  localparam int unsigned OFS_MASK_RD  = 'h10;
  localparam int unsigned OFS_STATUS   = 'h14;

  // strobes from the decode control to the register datapath
  typedef struct packed {
    logic setMask;
    logic clrMask;
    logic clrStat;
    logic rdMask;
    logic rdStat;
  } irqStrb_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output irqStrb_t          strb
);

  logic hitSet, hitClr, hitMask, hitStat;

  assign hitSet  = (busAddr == ADDR_W'(OFS_MASK_SET));
  assign hitClr  = (busAddr == ADDR_W'(OFS_MASK_CLR));
  assign hitMask = (busAddr == ADDR_W'(OFS_MASK_RD));
  assign hitStat = (busAddr == ADDR_W'(OFS_STATUS));

  always_comb begin
    strb         = '0;
    strb.setMask = busWr & hitSet;
    strb.clrMask = busWr & hitClr;
    strb.clrStat = busWr & hitStat;
    // the mask offset is read-only and both update offsets read back zero
    strb.rdMask  = hitMask;
    strb.rdStat  = hitStat;
  end

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrb_t           strb,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic [NUM_SRC-1:0] srcEvt,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] statQ,
  output logic               irqOut
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] maskNext;
  logic [NUM_SRC-1:0] statNext;

  always_comb begin
    maskNext = maskQ;
    if (strb.setMask) maskNext = maskQ | wrBits;
    if (strb.clrMask) maskNext = maskQ & ~wrBits;
  end

  // per-source sticky bit: an event in the same cycle beats a clearing write
  for (genvar b = 0; b < NUM_SRC; b++) begin : gStat
    assign statNext[b] = srcEvt[b] | (statQ[b] & ~(strb.clrStat & wrBits[b]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      statQ  <= '0;
      irqOut <= 1'b0;
    end else begin
      maskQ  <= maskNext;
      statQ  <= statNext;
      irqOut <= |(statQ & maskQ);
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdMask) busRdata = {{PAD_W{1'b0}}, maskQ};
    if (strb.rdStat) busRdata = {{PAD_W{1'b0}}, statQ};
  end

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcEvt,
  output logic               irqOut
);

  irqStrb_t           strb;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] statQ;
  logic               unusedWdataHi;

  // write-data bits above the source count carry no meaning
  assign unusedWdataHi = ^busWdata[DATA_W-1:NUM_SRC];

  uart_irq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr),
    .busWr  (busWr),
    .strb   (strb)
  );

  uart_irq_datapath #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrBits  (busWdata[NUM_SRC-1:0]),
    .srcEvt  (srcEvt),
    .busRdata(busRdata),
    .maskQ   (maskQ),
    .statQ   (statQ),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 13
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic [NUM_SRC-1:0] srcEvt,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] statQ
);

  logic [NUM_SRC-1:0] wb;
  logic aSet, aClr, aMask, aStat;
  assign wb    = busWdata[NUM_SRC-1:0];
  assign aSet  = (busAddr == ADDR_W'(OFS_MASK_SET));
  assign aClr  = (busAddr == ADDR_W'(OFS_MASK_CLR));
  assign aMask = (busAddr == ADDR_W'(OFS_MASK_RD));
  assign aStat = (busAddr == ADDR_W'(OFS_STATUS));

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (maskQ == '0 && statQ == '0 && !irqOut));

  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && aSet) |=> ((maskQ & $past(wb)) == $past(wb)) &&
                        ((maskQ & ~$past(wb)) == ($past(maskQ) & ~$past(wb))));

  p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && aClr) |=> ((maskQ & $past(wb)) == '0) &&
                        ((maskQ & ~$past(wb)) == ($past(maskQ) & ~$past(wb))));

  p_mask_ro_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && aMask) |=> $stable(maskQ));

  p_rd_pad_r4: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:NUM_SRC] == '0);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && aStat) |=> statQ == ($past(statQ) | $past(srcEvt)));

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && aStat) |=> (statQ & $past(wb) & ~$past(srcEvt)) == '0);

  p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|srcEvt) |=> (statQ & $past(srcEvt)) == $past(srcEvt));

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> irqOut == (|($past(statQ) & $past(maskQ))));

  p_update_reads_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (aSet || aClr) |-> busRdata == '0);

endmodule

bind uart_irq_unit uart_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .busWdata(busWdata), .busRdata(busRdata), .srcEvt(srcEvt),
  .irqOut(irqOut), .maskQ(maskQ), .statQ(statQ)
);

// File: tb/tb_uart_irq_unit.sv
module tb_uart_irq_unit;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NS = 13;

  localparam logic [AW-1:0] A_SET  = 8'h08;
  localparam logic [AW-1:0] A_CLR  = 8'h0C;
  localparam logic [AW-1:0] A_MASK = 8'h10;
  localparam logic [AW-1:0] A_STAT = 8'h14;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWr = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [NS-1:0] srcEvt = '0;
  logic          irqOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_unit dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .srcEvt(srcEvt), .irqOut(irqOut)
  );

  typedef struct {
    string         tag;
    logic          isIrq;
    logic [DW-1:0] exp;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state built from the requirements alone
  logic [NS-1:0] mdlMask = '0;
  logic [NS-1:0] mdlStat = '0;
  logic          mdlIrq  = 1'b0;

  // driver: apply one cycle of stimulus, queue what the outputs must show
  task automatic step(input logic [AW-1:0] a, input logic wr,
                      input logic [DW-1:0] wd, input logic [NS-1:0] ev,
                      input string tag);
    item_t it;
    logic [DW-1:0] rd;
    logic nIrq;
    @(posedge clk); #1;
    busAddr = a; busWr = wr; busWdata = wd; srcEvt = ev;
    rd = '0;
    if (a == A_MASK) rd = {{(DW-NS){1'b0}}, mdlMask};
    if (a == A_STAT) rd = {{(DW-NS){1'b0}}, mdlStat};
    it.tag = tag; it.isIrq = 1'b0; it.exp = rd;
    expQ.push_back(it);
    it.tag = tag; it.isIrq = 1'b1; it.exp = {{(DW-1){1'b0}}, mdlIrq};
    expQ.push_back(it);
    nIrq = |(mdlStat & mdlMask);
    if (wr && a == A_SET) mdlMask = mdlMask | wd[NS-1:0];
    if (wr && a == A_CLR) mdlMask = mdlMask & ~wd[NS-1:0];
    if (wr && a == A_STAT) mdlStat = mdlStat & ~wd[NS-1:0];
    mdlStat = mdlStat | ev;
    mdlIrq = nIrq;
  endtask

  // monitor: compare at mid-cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        item_t it;
        logic [DW-1:0] act;
        it = expQ.pop_front();
        act = it.isIrq ? {{(DW-1){1'b0}}, irqOut} : busRdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s %s actual=%h expected=%h", it.tag,
                   it.isIrq ? "irqOut" : "busRdata", act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    step(A_MASK, 0, '0, '0, "R1");
    step(A_STAT, 0, '0, '0, "R1");

    // R9: update offsets and unmapped offsets read zero
    step(A_SET, 0, '0, '0, "R9");
    step(A_CLR, 0, '0, '0, "R9");
    step(8'h00, 0, '0, '0, "R9");
    step(8'h3C, 0, '0, '0, "R9");

    // R2: set-only mask writes, zeros leave bits alone
    step(A_SET, 1, 32'h0000_0005, '0, "R2");
    step(A_MASK, 0, '0, '0, "R2");
    step(A_SET, 1, 32'h0000_0100, '0, "R2");
    step(A_MASK, 0, '0, '0, "R2");

    // R4: mask offset is read-only
    step(A_MASK, 1, 32'hFFFF_FFFF, '0, "R4");
    step(A_MASK, 0, '0, '0, "R4");

    // R9: write to an unmapped offset has no effect
    step(8'h00, 1, 32'hFFFF_FFFF, '0, "R9");
    step(A_MASK, 0, '0, '0, "R9");

    // R3: clear-only mask writes
    step(A_CLR, 1, 32'h0000_0001, '0, "R3");
    step(A_MASK, 0, '0, '0, "R3");

    // R10 and R5: walk each source, status builds up bit by bit
    for (int i = 0; i < NS; i++) step(A_STAT, 0, '0, NS'(1) << i, "R10");
    step(A_STAT, 0, '0, '0, "R5");
    step(A_STAT, 0, '0, '0, "R5");

    // R8: masked status raises irq; clearing status drops it
    step(A_STAT, 1, 32'h0000_1FFF, '0, "R8");
    step(A_STAT, 0, '0, '0, "R8");
    step(A_STAT, 0, '0, '0, "R8");

    // R6: partial clear of status
    step(A_STAT, 0, '0, 13'h0F0, "R6");
    step(A_STAT, 1, 32'h0000_0030, '0, "R6");
    step(A_STAT, 0, '0, '0, "R6");

    // R7: event and clear on the same bit in the same cycle
    step(A_STAT, 1, 32'h0000_00C0, 13'h040, "R7");
    step(A_STAT, 0, '0, '0, "R7");
    step(A_STAT, 0, '0, '0, "R7");

    // R8: status present but nothing masked in keeps irq low
    step(A_CLR, 1, 32'h0000_1FFF, 13'h100, "R8");
    step(A_STAT, 0, '0, '0, "R8");
    step(A_STAT, 0, '0, '0, "R8");
    step(A_SET, 1, 32'h0000_0100, '0, "R8");
    step(A_MASK, 0, '0, '0, "R8");
    step(A_MASK, 0, '0, '0, "R8");

    // R2 and R4: full mask, upper read bits zero
    step(A_SET, 1, 32'hFFFF_FFFF, '0, "R2");
    step(A_MASK, 0, '0, '0, "R4");
    step(8'h00, 0, '0, '0, "R9");

    @(negedge clk); #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule